// File: doc/BRIEF.md
# Flash Engine Ready/Busy Status Pin Generator

This block produces the open-drain status pin of a flash write engine. It looks at the engine's busy flag, its erase-suspended and program-suspended flags, a deep power-down input and two completion strobes, one for erase and one for program. From these it decides each cycle whether the pin is pulled low or released to high impedance. The pin value seen on the board is modelled as high when released, as if an external pull-up were fitted.

The pin runs in one of four modes, chosen at run time by a configuration write. The default level mode makes the pin an active-low busy flag. The three pulse modes turn it into an interrupt line that gives a fixed-width low pulse on selected completion events, so that unwanted events can be masked, for example background erase completion. Power-down releases the pin, cancels any pulse and returns the block to level mode, as reset does.

Top module: `stsPinGen`

## Requirements
- R1: While reset (`rstN` low) is asserted and after it is released, the mode is level (code 0) and the pin is released (`pinOe`=0, `pinVal`=1).
- R2: In level mode, when the engine is busy with neither suspend flag set and power-down low at a rising edge, `pinOe` is 1 from that edge until the next edge.
- R3: In level mode, when busy is low or either suspend flag is high at a rising edge, the pin is released after that edge.
- R4: A configuration write (`cfgWe`=1) with power-down low loads `cfgCode` as the mode at that edge: 0 level, 1 pulse on erase completion, 2 pulse on program completion, 3 pulse on either. Any pulse in progress is cancelled.
- R5: In a pulse mode, an enabled completion strobe at an edge drives the pin low for exactly PULSE_LEN cycles starting after that edge, then releases it. Busy and suspend flags have no effect in pulse modes.
- R6: A completion strobe that the current mode does not enable has no effect on the pin.
- R7: An enabled strobe that arrives while a pulse is running restarts the low time at a full PULSE_LEN cycles.
- R8: Power-down high at an edge releases the pin after that edge in every mode, cancels any pulse and sets level mode. Configuration writes made while it is high are ignored.
- R9: `pinVal` is 0 exactly when `pinOe` is 1, and 1 otherwise.
- R10: When a configuration write and an enabled strobe arrive at the same edge, the write takes effect and no pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| engBusy | input | 1 | Write engine is running an operation |
| eraseSusp | input | 1 | Erase is suspended |
| progSusp | input | 1 | Program is suspended |
| pwrDown | input | 1 | Deep power-down request |
| eraseDone | input | 1 | One-cycle strobe: erase finished |
| progDone | input | 1 | One-cycle strobe: program finished |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCode | input | 2 | Mode code loaded on a configuration write |
| pinOe | output | 1 | Pull the pin low when 1 |
| pinVal | output | 1 | Resulting pin level with pull-up |

## Verification
Every output is registered, so every input sampled at a rising edge shows at the pin right after that edge. A pulse stays low for PULSE_LEN cycles and drops after the PULSE_LEN-th following edge. The bench drives inputs just after a rising edge and compares the outputs at the falling edge with a cycle model that it updates at the same rising edges, so each result is checked in the cycle it is due. The pulse-width and retrigger cases are checked in every cycle of the pulse, including the first cycle after it ends.

// File: rtl/stsPkg.sv
package stsPkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_ERASE = 2'd1,
    MODE_PROG  = 2'd2,
    MODE_ANY   = 2'd3
  } stsMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic levelMode;   // pin follows the level flag
    logic loadPulse;   // start or restart a pulse
    logic clearPulse;  // cancel pulse (configuration write)
    logic clearAll;    // power-down: release everything
  } stsCtrl_t;

endpackage

// File: rtl/stsCtrl.sv
module stsCtrl
  import stsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       cfgWe,
  input  logic [1:0] cfgCode,
  input  logic       eraseDone,
  input  logic       progDone,
  output stsMode_e   mode,
  output stsCtrl_t   ctrl
);

  logic evtHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mode <= MODE_LEVEL;
    else if (pwrDown) mode <= MODE_LEVEL;
    else if (cfgWe)   mode <= stsMode_e'(cfgCode);
  end

  always_comb begin
    unique case (mode)
      MODE_ERASE: evtHit = eraseDone;
      MODE_PROG:  evtHit = progDone;
      MODE_ANY:   evtHit = eraseDone | progDone;
      default:    evtHit = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.levelMode  = (mode == MODE_LEVEL);
    ctrl.clearAll   = pwrDown;
    ctrl.clearPulse = cfgWe;
    ctrl.loadPulse  = evtHit & ~pwrDown & ~cfgWe;
  end

endmodule

// File: rtl/stsDatapath.sv
module stsDatapath
  import stsPkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  stsCtrl_t ctrl,
  input  logic     engBusy,
  input  logic     eraseSusp,
  input  logic     progSusp,
  output logic     pinOe,
  output logic     pinVal
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic             levelQ;
  logic [CNT_W-1:0] pulseCnt;
  logic             pulseOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              levelQ <= 1'b0;
    else if (ctrl.clearAll) levelQ <= 1'b0;
    else                    levelQ <= engBusy & ~eraseSusp & ~progSusp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                pulseCnt <= '0;
    else if (ctrl.clearAll | ctrl.clearPulse) pulseCnt <= '0;
    else if (ctrl.loadPulse)                  pulseCnt <= CNT_LOAD;
    else if (pulseOn)                         pulseCnt <= pulseCnt - 1'b1;
  end

  assign pulseOn = (pulseCnt != '0);
  assign pinOe   = ctrl.levelMode ? levelQ : pulseOn;
  assign pinVal  = ~pinOe;

endmodule

// File: rtl/stsPinGen.sv
module stsPinGen
  import stsPkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       engBusy,
  input  logic       eraseSusp,
  input  logic       progSusp,
  input  logic       pwrDown,
  input  logic       eraseDone,
  input  logic       progDone,
  input  logic       cfgWe,
  input  logic [1:0] cfgCode,
  output logic       pinOe,
  output logic       pinVal
);

  stsMode_e curMode;
  stsCtrl_t ctrlBus;

  stsCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDown   (pwrDown),
    .cfgWe     (cfgWe),
    .cfgCode   (cfgCode),
    .eraseDone (eraseDone),
    .progDone  (progDone),
    .mode      (curMode),
    .ctrl      (ctrlBus)
  );

  stsDatapath #(.PULSE_LEN(PULSE_LEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .engBusy   (engBusy),
    .eraseSusp (eraseSusp),
    .progSusp  (progSusp),
    .pinOe     (pinOe),
    .pinVal    (pinVal)
  );

endmodule

// File: rtl/stsPinChk.sv
module stsPinChk (
  input logic       clk,
  input logic       rstN,
  input logic       engBusy,
  input logic       eraseSusp,
  input logic       progSusp,
  input logic       pwrDown,
  input logic       eraseDone,
  input logic       progDone,
  input logic       cfgWe,
  input logic [1:0] cfgCode,
  input logic [1:0] curMode,
  input logic       pinOe
);

  logic enabledEvt;
  assign enabledEvt = (curMode == 2'd1 && eraseDone) ||
                      (curMode == 2'd2 && progDone) ||
                      (curMode == 2'd3 && (eraseDone || progDone));

  AST_LEVEL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd0 && !cfgWe && !pwrDown && engBusy && !eraseSusp && !progSusp) |=> pinOe); // R2

  AST_SUSP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd0 && !cfgWe && (eraseSusp || progSusp)) |=> !pinOe); // R3

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !pwrDown) |=> (curMode == $past(cfgCode))); // R4

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != 2'd0 && !cfgWe && !pwrDown && enabledEvt) |=> pinOe); // R5

  AST_MASKED_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'd1 && !pinOe && !cfgWe && progDone && !eraseDone) |=> !pinOe); // R6

  AST_PWRDN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (!pinOe && curMode == 2'd0)); // R8

endmodule

bind stsPinGen stsPinChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .engBusy   (engBusy),
  .eraseSusp (eraseSusp),
  .progSusp  (progSusp),
  .pwrDown   (pwrDown),
  .eraseDone (eraseDone),
  .progDone  (progDone),
  .cfgWe     (cfgWe),
  .cfgCode   (cfgCode),
  .curMode   (curMode),
  .pinOe     (pinOe)
);

// File: tb/sim_stsPinGen.sv
`timescale 1ns/1ps
module sim_stsPinGen;

  localparam int PL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic engBusy = 0, eraseSusp = 0, progSusp = 0, pwrDown = 0;
  logic eraseDone = 0, progDone = 0, cfgWe = 0;
  logic [1:0] cfgCode = 2'd0;
  logic pinOe, pinVal;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit checking = 0;
  string curTag = "R1";

  // reference model state
  int mMode = 0;
  int mCnt  = 0;
  bit mLvl  = 0;

  always #4 clk = ~clk;

  stsPinGen #(.PULSE_LEN(PL)) u0 (
    .clk(clk), .rstN(rstN), .engBusy(engBusy), .eraseSusp(eraseSusp),
    .progSusp(progSusp), .pwrDown(pwrDown), .eraseDone(eraseDone),
    .progDone(progDone), .cfgWe(cfgWe), .cfgCode(cfgCode),
    .pinOe(pinOe), .pinVal(pinVal)
  );

  function automatic bit evtEnabled(int md, bit ed, bit pd);
    case (md)
      1: return ed;
      2: return pd;
      3: return ed | pd;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expOe();
    if (mMode == 0) return mLvl;
    return (mCnt != 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode <= 0; mCnt <= 0; mLvl <= 0;
    end else begin
      mLvl <= pwrDown ? 1'b0 : (engBusy & ~eraseSusp & ~progSusp);
      if (pwrDown) begin
        mMode <= 0; mCnt <= 0;
      end else if (cfgWe) begin
        mMode <= int'(cfgCode); mCnt <= 0;
      end else if (evtEnabled(mMode, eraseDone, progDone)) begin
        mCnt <= PL;
      end else if (mCnt != 0) begin
        mCnt <= mCnt - 1;
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rstN) begin
      check(curTag, pinOe, expOe());
      check("R9", pinVal, ~expOe());
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg(int code);
    cfgWe = 1; cfgCode = 2'(code); tick(1); cfgWe = 0;
  endtask

  task automatic strobe(bit e, bit p);
    eraseDone = e; progDone = p; tick(1); eraseDone = 0; progDone = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51A7));
    #10;
    check("R1", pinOe, 1'b0);   // during reset
    check("R1", pinVal, 1'b1);
    tick(1); rstN = 1; checking = 1;
    tick(3);                    // R1 after release via model

    // R2 / R3 level mode
    curTag = "R2"; engBusy = 1; tick(4);
    curTag = "R3"; eraseSusp = 1; tick(2); eraseSusp = 0; progSusp = 1; tick(2);
    progSusp = 0; tick(2); engBusy = 0; tick(2);

    // R4 / R5 pulse on erase, busy ignored
    curTag = "R4"; cfg(1); tick(1);
    curTag = "R5"; engBusy = 1; strobe(1, 0); tick(PL + 2); engBusy = 0;
    // R6 masked program event
    curTag = "R6"; strobe(0, 1); tick(3);
    cfg(2); strobe(1, 0); tick(3);
    // R7 retrigger
    curTag = "R7"; cfg(3); strobe(0, 1); tick(PL - 3); strobe(1, 0); tick(PL + 2);
    // R4 config write cancels pulse
    curTag = "R4"; strobe(1, 1); tick(2); cfg(3); tick(3);
    // R10 write and event together
    curTag = "R10"; cfgWe = 1; cfgCode = 2'd3; eraseDone = 1; tick(1);
    cfgWe = 0; eraseDone = 0; tick(3);
    // R8 power-down mid pulse, writes ignored, returns level mode
    curTag = "R8"; strobe(1, 0); tick(2);
    pwrDown = 1; tick(1); cfgWe = 1; cfgCode = 2'd2; tick(1); cfgWe = 0; tick(2);
    pwrDown = 0; engBusy = 1; tick(3); engBusy = 0; strobe(0, 1); tick(3);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      curTag = (mMode == 0) ? "R2" : "R5";
      engBusy   = ($urandom_range(0, 1) == 1);
      eraseSusp = ($urandom_range(0, 9) == 0);
      progSusp  = ($urandom_range(0, 9) == 0);
      pwrDown   = ($urandom_range(0, 39) == 0);
      cfgWe     = ($urandom_range(0, 24) == 0);
      cfgCode   = 2'($urandom_range(0, 3));
      eraseDone = ($urandom_range(0, 11) == 0);
      progDone  = ($urandom_range(0, 11) == 0);
      tick(1);
    end
    {engBusy, eraseSusp, progSusp, pwrDown, cfgWe, eraseDone, progDone} = '0;
    tick(PL + 2);

    checking = 0;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule